// File: doc/BRIEF.md
# Two-Wire Control Register Bank

This block is a two-wire serial slave that owns a small bank of 8-bit control bytes. Each byte drives parallel outputs used elsewhere in the chip to switch individual outputs on or off and to pick operating modes. The bytes come out of reset with per-register default values, so the chip runs correctly even if the serial bus is never touched.

The slave has no register pointer. A write transaction carries the device address with the direction bit clear, then a command byte and a byte-count byte, both acknowledged and thrown away, and then data bytes that land in register 0, register 1 and onward until the master sends stop. To change register k the master must therefore resend registers 0 to k-1 in the same transaction. A read transaction carries the address with the direction bit set, and the slave then streams register 0, register 1 and onward. After each byte the master acknowledges, and a master not-acknowledge ends the stream. SCL and SDA are brought into the system clock domain through two-flop synchronizers, and start, stop and clock edges are detected on the synchronized copies. SDA is driven as an open-drain enable.

The controller has seven states. IDLE waits for a start. ADDR shifts in the address byte. ADDR_ACK drives the acknowledge for a matching address. WR_BYTE shifts in a command, count or data byte. WR_ACK acknowledges it. RD_BYTE shifts a register out MSB first. RD_ACK samples the master's acknowledge. The transitions are as follows. A start from any state goes to ADDR, and a stop from any state goes to IDLE. ADDR goes to ADDR_ACK after eight bits if the address matches, and to IDLE if it does not. ADDR_ACK goes to RD_BYTE or WR_BYTE according to the direction bit. WR_BYTE goes to WR_ACK, and WR_ACK goes back to WR_BYTE. RD_BYTE goes to RD_ACK. RD_ACK goes to RD_BYTE when the master acknowledges and to IDLE when it does not. Every move except start and stop happens on a falling SCL edge.

Top module: `twi_ctrl_bank`

## Requirements
- R1: After reset, with the default parameters, ctrl_out bytes 0 to 5 (byte k at bits 8k+7:8k) are 0x81, 0xC3, 0x00, 0x5A, 0xFF and 0x0F, and sda_oe is 0.
- R2: The slave answers only to the 7-bit address 1101001, which gives first byte 0xD2 for a write and 0xD3 for a read. For a matching address it pulls SDA low during the acknowledge bit. For any other address it leaves SDA released on that bit and on every later bit until the next start, and no register changes.
- R3: In a write, the command byte and the count byte are acknowledged and discarded. The following data bytes are acknowledged and stored into registers 0, 1, 2 and so on, in the order sent.
- R4: Registers that a write does not reach keep their previous values.
- R5: Data bytes beyond the last register are acknowledged and do not change any register.
- R6: A read returns register 0 first, then the following registers in order, each MSB first, with SDA changed only while SCL is low.
- R7: A read past the last register returns 0xFF.
- R8: A master not-acknowledge on a read byte makes the slave release SDA and return to idle, and the next transaction is served normally.
- R9: Every transaction, including one opened by a repeated start, begins at register 0. A stop returns the slave to idle.
- R10: sda_oe never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ctrl_out | output | NREG*8 | Control bytes, register k at bits 8k+7:8k |

## Verification
The hardest case to reach is a repeated start that arrives in the middle of a write stream and turns the transaction into a read. The slave must stop its write byte index, restart at register 0, and return the byte it has just stored. The stimulus writes one data byte, raises SDA while SCL is low, forms a fresh start without a stop, and then reads registers 0 and 1. A second hard case is the extra data bytes past the last register. The bench sends three more bytes than the bank holds and checks both that they are acknowledged and that the parallel outputs stay unchanged.

// File: rtl/twi_bank_pkg.sv
package twi_bank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } twi_state_t;

    typedef logic [7:0] byte_t;

    localparam int BITS_PER_BYTE = 8;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync,
    output logic line_prev
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= chain[STAGES-1];
    end

    assign line_sync = chain[STAGES-1];

endmodule

// File: rtl/twi_reg_store.sv
module twi_reg_store
    import twi_bank_pkg::*;
#(
    parameter int               NREG      = 6,
    parameter int               IDXW      = 5,
    parameter logic [NREG*8-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDXW-1:0]   waddr,
    input  byte_t             wdata,
    input  logic [IDXW-1:0]   raddr,
    output byte_t             rdata,
    output logic [NREG*8-1:0] regs_flat
);

    byte_t regs [NREG];

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[k] <= RESET_VAL[k*8 +: 8];
                else if (we && (waddr == IDXW'(k)))
                    regs[k] <= wdata;
            end
            assign regs_flat[k*8 +: 8] = regs[k];
        end
    endgenerate

    always_comb begin
        rdata = 8'hFF;
        for (int k = 0; k < NREG; k++) begin
            if (raddr == IDXW'(k)) rdata = regs[k];
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < IDXW'(NREG)));  // R5

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));  // R4

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_bank_pkg::*;
#(
    parameter int         NREG     = 6,
    parameter int         IDXW     = 5,
    parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s,
    input  logic            scl_p,
    input  logic            sda_s,
    input  logic            sda_p,
    input  byte_t           rdata,
    output logic [IDXW-1:0] raddr,
    output logic            we,
    output logic [IDXW-1:0] waddr,
    output byte_t           wdata,
    output logic            sda_oe
);

    localparam int          CNTW     = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(BITS_PER_BYTE);
    localparam int          HDR      = 2;
    localparam logic [IDXW-1:0] IDX_MAX = {IDXW{1'b1}};

    twi_state_t      state, state_nx;
    byte_t           shreg;
    logic [CNTW-1:0] bitcnt;
    logic [IDXW-1:0] idx;
    logic            rw;
    logic            nack;

    logic scl_rise, scl_fall, bus_start, bus_stop, byte_end;

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
    assign byte_end  = scl_fall && (bitcnt == FULL);

    // next state
    always_comb begin
        state_nx = state;
        if (bus_stop) begin
            state_nx = ST_IDLE;
        end else if (bus_start) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_end)
                                 state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_nx = rw ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_nx = nack ? ST_IDLE : ST_RD_BYTE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            idx    <= '0;
            rw     <= 1'b0;
            nack   <= 1'b0;
        end else if (bus_start || bus_stop) begin
            bitcnt <= '0;
            idx    <= '0;
            nack   <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            rw  <= shreg[0];
                            idx <= '0;
                        end else if (idx != IDX_MAX) begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw) begin
                        shreg <= rdata;
                        idx   <= idx + 1'b1;
                        nack  <= 1'b0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                    end else if (scl_fall) begin
                        shreg <= {shreg[6:0], 1'b1};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        nack <= sda_s;
                    end else if (scl_fall && !nack) begin
                        shreg <= rdata;
                        if (idx != IDX_MAX) idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        we     = 1'b0;
        waddr  = idx - IDXW'(HDR);
        wdata  = shreg;
        raddr  = idx;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~shreg[7];
            ST_WR_BYTE:             we = byte_end && !bus_stop && !bus_start &&
                                         (idx >= IDXW'(HDR)) &&
                                         (idx < IDXW'(HDR + NREG));
            default: ;
        endcase
    end

    AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && scl_p) |=> (!scl_s || $stable(sda_oe)));  // R10

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state == ST_IDLE));  // R9

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (state == ST_ADDR && idx == '0));  // R9

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= FULL);  // R3

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && nack && !bus_start && !bus_stop)
            |=> (state == ST_IDLE && !sda_oe));  // R8

endmodule

// File: rtl/twi_ctrl_bank.sv
module twi_ctrl_bank
    import twi_bank_pkg::*;
#(
    parameter int                NREG      = 6,
    parameter logic [6:0]        DEV_ADDR  = 7'b1101001,
    parameter int                SYNC_STG  = 2,
    parameter logic [NREG*8-1:0] RESET_VAL = 48'h0F_FF_5A_00_C3_81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] ctrl_out
);

    localparam int IDXW = $clog2(NREG + 3) + 1;

    logic [1:0] line_raw, line_s, line_p;
    assign line_raw = {sda_in, scl_in};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            twi_line_sync #(.STAGES(SYNC_STG)) u_sync (
                .clk       (clk),
                .rst_n     (rst_n),
                .line_in   (line_raw[g]),
                .line_sync (line_s[g]),
                .line_prev (line_p[g])
            );
        end
    endgenerate

    logic            we;
    logic [IDXW-1:0] waddr, raddr;
    byte_t           wdata, rdata;

    twi_slave_fsm #(
        .NREG     (NREG),
        .IDXW     (IDXW),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (line_s[0]),
        .scl_p  (line_p[0]),
        .sda_s  (line_s[1]),
        .sda_p  (line_p[1]),
        .rdata  (rdata),
        .raddr  (raddr),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .sda_oe (sda_oe)
    );

    twi_reg_store #(
        .NREG      (NREG),
        .IDXW      (IDXW),
        .RESET_VAL (RESET_VAL)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (raddr),
        .rdata     (rdata),
        .regs_flat (ctrl_out)
    );

endmodule

// File: tb/twi_ctrl_bank_tb.sv
module twi_ctrl_bank_tb;

    localparam int NREG = 6;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] ctrl_out;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    twi_ctrl_bank u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .ctrl_out (ctrl_out)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    item_t exp_q[$];
    item_t obs_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int oe_viol = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares observed bus results against the expected queue
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                item_t o;
                item_t e;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    check({o.tag, " (no expectation)"}, 64'(o.val), 64'hX);
                end else begin
                    e = exp_q.pop_front();
                    check(e.tag, 64'(o.val), 64'(e.val));
                end
            end
        end
    end

    // R10: open-drain enable must not move while SCL is high
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) oe_viol++;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        exp_q.push_back('{tag, {7'd0, exp_ack}});
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HALF/2);
            sda_m = b[i];
            wait_clk(HALF/2);
            scl_m = 1'b1; wait_clk(HALF);
            scl_m = 1'b0;
        end
        wait_clk(HALF/2);
        sda_m = 1'b1;
        wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF/2);
        a = sda_line;
        wait_clk(HALF/2);
        scl_m = 1'b0;
        obs_q.push_back('{tag, {7'd0, a}});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic [7:0] b;
        exp_q.push_back('{tag, exp});
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HALF);
            scl_m = 1'b1; wait_clk(HALF/2);
            b[i] = sda_line;
            wait_clk(HALF/2);
            scl_m = 1'b0;
        end
        wait_clk(HALF/2);
        sda_m = mack;
        wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(HALF/2);
        sda_m = 1'b1;
        obs_q.push_back('{tag, b});
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int k = 0; k < NREG; k++) f[k*8 +: 8] = model[k];
        return f;
    endfunction

    task automatic write_regs(input logic [7:0] d [], input string tag);
        bus_start();
        send_byte(8'hD2, 1'b0, {tag, " R2 addr ack"});
        send_byte(8'h00, 1'b0, {tag, " R3 cmd ack"});
        send_byte(8'(d.size()), 1'b0, {tag, " R3 count ack"});
        foreach (d[i]) begin
            send_byte(d[i], 1'b0, (i < NREG) ? {tag, " R3 data ack"} : {tag, " R5 extra ack"});
            if (i < NREG) model[i] = d[i];
        end
        bus_stop();
    endtask

    task automatic read_regs(input int n, input string tag);
        bus_start();
        send_byte(8'hD3, 1'b0, {tag, " R2 read addr ack"});
        for (int i = 0; i < n; i++) begin
            recv_byte((i < NREG) ? model[i] : 8'hFF, (i == n-1),
                      (i < NREG) ? {tag, " R6 read byte"} : {tag, " R7 past end 0xFF"});
        end
        bus_stop();
    endtask

    initial begin
        logic [7:0] d [];
        model[0] = 8'h81; model[1] = 8'hC3; model[2] = 8'h00;
        model[3] = 8'h5A; model[4] = 8'hFF; model[5] = 8'h0F;
        wait_clk(5);
        check("R1 reset ctrl_out", 64'(ctrl_out), 64'(model_flat()));
        check("R1 reset sda_oe", 64'(sda_oe), 64'd0);
        rst_n = 1'b1;
        wait_clk(10);

        // defaults read back, plus two bytes past the end, last one NACKed
        read_regs(NREG + 2, "rd_default");
        wait_clk(HALF);
        check("R8 sda released after NACK", 64'(sda_oe), 64'd0);

        // partial write: registers 0..2 only
        d = new[3];
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        write_regs(d, "wr_partial");
        wait_clk(HALF);
        check("R3 R4 ctrl_out after partial write", 64'(ctrl_out), 64'(model_flat()));

        // foreign address: no ack anywhere, nothing stored
        bus_start();
        send_byte(8'hA4, 1'b1, "R2 foreign addr nack");
        send_byte(8'h00, 1'b1, "R2 foreign cmd nack");
        send_byte(8'h01, 1'b1, "R2 foreign count nack");
        send_byte(8'h99, 1'b1, "R2 foreign data nack");
        bus_stop();
        wait_clk(HALF);
        check("R2 ctrl_out unchanged by foreign address", 64'(ctrl_out), 64'(model_flat()));

        // overlong write: every register plus three extra bytes
        d = new[NREG + 3];
        foreach (d[i]) d[i] = 8'hA0 + 8'(i);
        write_regs(d, "wr_long");
        wait_clk(HALF);
        check("R5 extra bytes ignored", 64'(ctrl_out), 64'(model_flat()));

        // repeated start from write into read: stream restarts at register 0
        bus_start();
        send_byte(8'hD2, 1'b0, "R9 rs addr ack");
        send_byte(8'h00, 1'b0, "R9 rs cmd ack");
        send_byte(8'h01, 1'b0, "R9 rs count ack");
        send_byte(8'h5C, 1'b0, "R9 rs data ack");
        model[0] = 8'h5C;
        bus_start();
        send_byte(8'hD3, 1'b0, "R9 rs read addr ack");
        recv_byte(model[0], 1'b0, "R9 rs read reg0");
        recv_byte(model[1], 1'b1, "R9 rs read reg1");
        bus_stop();
        wait_clk(HALF);
        check("R8 idle after NACK", 64'(sda_oe), 64'd0);

        // a fresh full read after the NACK is served from register 0
        read_regs(NREG, "rd_after");
        wait_clk(HALF);
        check("R4 final ctrl_out", 64'(ctrl_out), 64'(model_flat()));
        check("R10 sda_oe stable while SCL high", 64'(oe_viol), 64'd0);
        check("scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_clk(200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule